// File: doc/BRIEF.md
# PN Code Tracking Controller

This block produces a local pseudorandom spreading code and keeps its phase lined up with a received, already despread signal. The code comes from a 15-bit maximal-length linear feedback shift register (LFSR), clocked once per chip. The block's clock runs at the sample rate, and each chip lasts a fixed number of samples. Three taps of the code stream come out of the block. The early tap leads by one sample, the prompt tap is the reference, and the late tap lags by one sample. The prompt tap also spreads a data bit by XOR.

Once per dwell, an upstream measurement path supplies three unsigned power readings: early, prompt and late. The path marks them with a one-cycle valid pulse. If the prompt power is below a programmable threshold, the block slips the code one chip later and keeps searching. Otherwise it compares the early and late powers against a programmable dead band. It then advances the code, delays it, or declares lock and leaves the phase alone. A decision is held pending and applied at the next chip boundary, and a one-cycle strobe marks the adjustment.

Top module: `pn_track_ctrl`

## Requirements
- R1: While `rst_n` is low, `lock` and `adj_stb` are 0, the LFSR holds its seed (15'h0001 by default) and the prompt and late taps are 0. After `rst_n` rises, the internal reset is released on the second rising clock edge.
- R2: Each chip lasts `CHIP_SAMPLES` clocks (2 by default). With no adjustment pending, the LFSR takes one step on the last sample of each chip. A step is s <= {s[13:0], s[14]^s[13]}, and `code_early` is s[14].
- R3: `code_prompt` equals `code_early` delayed by one clock, and `code_late` equals `code_prompt` delayed by one clock.
- R4: `enc_out` equals `data_in` XOR `code_prompt` in the same cycle.
- R5: A valid measurement whose prompt power is below the threshold schedules a delay and clears `lock` on the next edge.
- R6: A valid measurement with prompt power at or above the threshold, and early power above late power plus the dead band, schedules an advance. At the next chip boundary the LFSR then takes two steps.
- R7: A valid measurement with prompt power at or above the threshold, and late power above early power plus the dead band, schedules a delay. At the next chip boundary the LFSR then takes no step.
- R8: A valid measurement with prompt power at or above the threshold, and early and late powers within the dead band of each other, cancels any pending adjustment and sets `lock` on the next edge.
- R9: `lock` changes only on a valid measurement. Advance and delay decisions for steering leave it unchanged.
- R10: `adj_stb` is high for exactly one clock, in the cycle after a chip boundary at which a pending advance or delay was applied. Each pending decision is applied once and then cleared.
- R11: A `cfg_wr` pulse loads the threshold from `cfg_thr` and the dead band from `cfg_band`, and they take effect from the next cycle. Reset sets the threshold to 8 and the dead band to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load threshold and dead band |
| cfg_thr | input | 8 | New detection threshold |
| cfg_band | input | 8 | New early/late dead band |
| meas_valid | input | 1 | One-cycle strobe marking a dwell's measurements |
| pwr_early | input | 8 | Early-tap power |
| pwr_prompt | input | 8 | Prompt-tap power |
| pwr_late | input | 8 | Late-tap power |
| data_in | input | 1 | Data bit to spread |
| code_early | output | 1 | Code one sample ahead of prompt |
| code_prompt | output | 1 | Reference code chip |
| code_late | output | 1 | Code one sample behind prompt |
| enc_out | output | 1 | Spread data bit |
| lock | output | 1 | Tracking lock flag |
| adj_stb | output | 1 | Phase-adjust pulse |

## Verification
The assertions assume that valid pulses arrive at least one chip period apart, so every pending decision reaches a chip boundary before another decision can replace it. The lock properties read the threshold and dead band currently held in the registers, not the configuration inputs. The stimulus writes the configuration with a lone `cfg_wr` pulse that never shares a cycle with `meas_valid`. It then issues each measurement as a single-cycle pulse followed by four idle clocks, which is two full chips at the default rate.

// File: rtl/pn_track_pkg.sv
package pn_track_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_ADV  = 2'd1,
    ADJ_DLY  = 2'd2
  } adj_e;
endpackage

// File: rtl/pn_rst_sync.sv
module pn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pn_code_gen.sv
module pn_code_gen
  import pn_track_pkg::*;
#(
  parameter int          LFSR_W       = 15,
  parameter int          TAP_A        = 15,
  parameter int          TAP_B        = 14,
  parameter logic [14:0] SEED         = 15'h0001,
  parameter int          CHIP_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_q_n,
  input  adj_e pend,
  output logic chip_tick,
  output logic code_early,
  output logic code_prompt,
  output logic code_late,
  output logic adj_stb
);
  localparam int CTR_W   = (CHIP_SAMPLES > 1) ? $clog2(CHIP_SAMPLES) : 1;
  localparam int TAP_LEN = 2;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[TAP_A-1] ^ s[TAP_B-1]};
  endfunction

  logic [CTR_W-1:0]  ctr_q, ctr_d;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [LFSR_W-1:0] one_step, two_step;
  logic              stb_q, stb_d;
  logic [TAP_LEN-1:0] tap_q;
  logic [TAP_LEN-1:0] tap_d;

  always_comb begin
    chip_tick = (ctr_q == CTR_W'(CHIP_SAMPLES - 1));
    ctr_d     = chip_tick ? '0 : ctr_q + 1'b1;
    one_step  = lfsr_step(lfsr_q);
    two_step  = lfsr_step(one_step);
    lfsr_d    = lfsr_q;
    stb_d     = 1'b0;
    if (chip_tick) begin
      unique case (pend)
        ADJ_ADV: lfsr_d = two_step;
        ADJ_DLY: lfsr_d = lfsr_q;
        default: lfsr_d = one_step;
      endcase
      stb_d = (pend != ADJ_NONE);
    end
  end

  generate
    for (genvar i = 0; i < TAP_LEN; i++) begin : g_tap
      if (i == 0) begin : g_first
        assign tap_d[i] = lfsr_q[LFSR_W-1];
      end else begin : g_rest
        assign tap_d[i] = tap_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctr_q  <= '0;
      lfsr_q <= SEED[LFSR_W-1:0];
      stb_q  <= 1'b0;
      tap_q  <= '0;
    end else begin
      ctr_q  <= ctr_d;
      lfsr_q <= lfsr_d;
      stb_q  <= stb_d;
      tap_q  <= tap_d;
    end
  end

  assign code_early  = lfsr_q[LFSR_W-1];
  assign code_prompt = tap_q[0];
  assign code_late   = tap_q[TAP_LEN-1];
  assign adj_stb     = stb_q;
endmodule

// File: rtl/pn_phase_decide.sv
module pn_phase_decide
  import pn_track_pkg::*;
#(
  parameter int PWR_W    = 8,
  parameter int THR_RST  = 8,
  parameter int BAND_RST = 1
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             cfg_wr,
  input  logic [PWR_W-1:0] cfg_thr,
  input  logic [PWR_W-1:0] cfg_band,
  input  logic             meas_valid,
  input  logic [PWR_W-1:0] pwr_early,
  input  logic [PWR_W-1:0] pwr_prompt,
  input  logic [PWR_W-1:0] pwr_late,
  input  logic             chip_tick,
  output adj_e             pend,
  output logic             lock,
  output logic [PWR_W-1:0] thr_cur,
  output logic [PWR_W-1:0] band_cur
);
  localparam int EXT_W = PWR_W + 1;

  logic [PWR_W-1:0] thr_q, thr_d, band_q, band_d;
  adj_e             pend_q, pend_d;
  logic             lock_q, lock_d;
  logic [EXT_W-1:0] early_x, late_x, early_lim, late_lim;

  always_comb begin
    early_x   = {1'b0, pwr_early};
    late_x    = {1'b0, pwr_late};
    early_lim = early_x + {1'b0, band_q};
    late_lim  = late_x + {1'b0, band_q};
    thr_d     = cfg_wr ? cfg_thr  : thr_q;
    band_d    = cfg_wr ? cfg_band : band_q;
    pend_d    = chip_tick ? ADJ_NONE : pend_q;
    lock_d    = lock_q;
    if (meas_valid) begin
      if (pwr_prompt < thr_q) begin
        pend_d = ADJ_DLY;
        lock_d = 1'b0;
      end else if (early_x > late_lim) begin
        pend_d = ADJ_ADV;
      end else if (late_x > early_lim) begin
        pend_d = ADJ_DLY;
      end else begin
        pend_d = ADJ_NONE;
        lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      thr_q  <= PWR_W'(THR_RST);
      band_q <= PWR_W'(BAND_RST);
      pend_q <= ADJ_NONE;
      lock_q <= 1'b0;
    end else begin
      thr_q  <= thr_d;
      band_q <= band_d;
      pend_q <= pend_d;
      lock_q <= lock_d;
    end
  end

  assign pend     = pend_q;
  assign lock     = lock_q;
  assign thr_cur  = thr_q;
  assign band_cur = band_q;
endmodule

// File: rtl/pn_track_ctrl.sv
module pn_track_ctrl
  import pn_track_pkg::*;
#(
  parameter int          PWR_W        = 8,
  parameter int          CHIP_SAMPLES = 2,
  parameter logic [14:0] SEED         = 15'h0001,
  parameter int          THR_RST      = 8,
  parameter int          BAND_RST     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [PWR_W-1:0] cfg_thr,
  input  logic [PWR_W-1:0] cfg_band,
  input  logic             meas_valid,
  input  logic [PWR_W-1:0] pwr_early,
  input  logic [PWR_W-1:0] pwr_prompt,
  input  logic [PWR_W-1:0] pwr_late,
  input  logic             data_in,
  output logic             code_early,
  output logic             code_prompt,
  output logic             code_late,
  output logic             enc_out,
  output logic             lock,
  output logic             adj_stb
);
  logic             rst_q_n;
  logic             chip_tick;
  adj_e             pend;
  logic [PWR_W-1:0] thr_cur, band_cur;

  pn_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  pn_phase_decide #(
    .PWR_W(PWR_W), .THR_RST(THR_RST), .BAND_RST(BAND_RST)
  ) u_decide (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .cfg_wr     (cfg_wr),
    .cfg_thr    (cfg_thr),
    .cfg_band   (cfg_band),
    .meas_valid (meas_valid),
    .pwr_early  (pwr_early),
    .pwr_prompt (pwr_prompt),
    .pwr_late   (pwr_late),
    .chip_tick  (chip_tick),
    .pend       (pend),
    .lock       (lock),
    .thr_cur    (thr_cur),
    .band_cur   (band_cur)
  );

  pn_code_gen #(
    .LFSR_W(15), .TAP_A(15), .TAP_B(14), .SEED(SEED), .CHIP_SAMPLES(CHIP_SAMPLES)
  ) u_code (
    .clk         (clk),
    .rst_q_n     (rst_q_n),
    .pend        (pend),
    .chip_tick   (chip_tick),
    .code_early  (code_early),
    .code_prompt (code_prompt),
    .code_late   (code_late),
    .adj_stb     (adj_stb)
  );

  assign enc_out = data_in ^ code_prompt;
endmodule

// File: rtl/pn_track_chk.sv
module pn_track_chk #(
  parameter int PWR_W = 8
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             meas_valid,
  input logic [PWR_W-1:0] pwr_early,
  input logic [PWR_W-1:0] pwr_prompt,
  input logic [PWR_W-1:0] pwr_late,
  input logic [PWR_W-1:0] thr_cur,
  input logic [PWR_W-1:0] band_cur,
  input logic             chip_tick,
  input logic             code_early,
  input logic             code_prompt,
  input logic             code_late,
  input logic             lock,
  input logic             adj_stb
);
  logic [1:0] age_q;
  logic       settled;
  logic       in_band;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)        age_q <= '0;
    else if (!age_q[1])  age_q <= age_q + 1'b1;
  end
  assign settled = age_q[1];
  assign in_band = ({1'b0, pwr_early} <= {1'b0, pwr_late} + {1'b0, band_cur}) &&
                   ({1'b0, pwr_late} <= {1'b0, pwr_early} + {1'b0, band_cur});

  AST_ADJ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    adj_stb |=> !adj_stb);  // R10
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (meas_valid && pwr_prompt < thr_cur) |=> !lock);  // R5
  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (meas_valid && pwr_prompt >= thr_cur && in_band) |=> lock);  // R8
  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    !meas_valid |=> $stable(lock));  // R9
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !chip_tick |=> $stable(code_early));  // R2
  AST_PROMPT_TAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    settled |-> code_prompt == $past(code_early));  // R3
  AST_LATE_TAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    settled |-> code_late == $past(code_prompt));  // R3
endmodule

bind pn_track_ctrl pn_track_chk #(.PWR_W(PWR_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .meas_valid  (meas_valid),
  .pwr_early   (pwr_early),
  .pwr_prompt  (pwr_prompt),
  .pwr_late    (pwr_late),
  .thr_cur     (thr_cur),
  .band_cur    (band_cur),
  .chip_tick   (chip_tick),
  .code_early  (code_early),
  .code_prompt (code_prompt),
  .code_late   (code_late),
  .lock        (lock),
  .adj_stb     (adj_stb)
);

// File: tb/pn_track_ctrl_bench.sv
module pn_track_ctrl_bench;
  localparam int PERIOD = 8;
  localparam int PW     = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [PW-1:0] cfg_thr, cfg_band;
  logic          meas_valid;
  logic [PW-1:0] pwr_early, pwr_prompt, pwr_late;
  logic          data_in;
  logic          code_early, code_prompt, code_late, enc_out, lock, adj_stb;

  int checks = 0;
  int errors = 0;
  bit run    = 1'b0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pn_track_ctrl u_pn_track_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_thr(cfg_thr), .cfg_band(cfg_band),
    .meas_valid(meas_valid), .pwr_early(pwr_early), .pwr_prompt(pwr_prompt),
    .pwr_late(pwr_late), .data_in(data_in), .code_early(code_early),
    .code_prompt(code_prompt), .code_late(code_late), .enc_out(enc_out),
    .lock(lock), .adj_stb(adj_stb)
  );

  // Reference model built from the requirements.
  logic          m_s1, m_s2;
  logic [14:0]   m_lfsr;
  logic          m_ctr;
  logic          m_t1, m_t2, m_lock, m_adj;
  logic [1:0]    m_pend;   // 0 none, 1 advance, 2 delay
  logic [PW-1:0] m_thr, m_band;

  function automatic logic [14:0] step(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  always @(posedge clk or negedge rst_n) begin  // R1 release after two edges
    if (!rst_n) begin m_s1 <= 1'b0; m_s2 <= 1'b0; end
    else        begin m_s1 <= 1'b1; m_s2 <= m_s1; end
  end

  always @(posedge clk or negedge m_s2) begin
    if (!m_s2) begin
      m_lfsr <= 15'h0001; m_ctr <= 1'b0; m_t1 <= 1'b0; m_t2 <= 1'b0;
      m_lock <= 1'b0; m_adj <= 1'b0; m_pend <= 2'd0; m_thr <= 8; m_band <= 1;
    end else begin
      logic [1:0] np;
      logic       nl;
      np = (m_ctr == 1'b1) ? 2'd0 : m_pend;
      nl = m_lock;
      if (meas_valid) begin
        if (pwr_prompt < m_thr) begin np = 2'd2; nl = 1'b0; end              // R5
        else if (int'(pwr_early) > int'(pwr_late) + int'(m_band)) np = 2'd1;  // R6
        else if (int'(pwr_late) > int'(pwr_early) + int'(m_band)) np = 2'd2;  // R7
        else begin np = 2'd0; nl = 1'b1; end                                 // R8
      end
      if (m_ctr == 1'b1) begin
        m_lfsr <= (m_pend == 2'd1) ? step(step(m_lfsr)) :
                  (m_pend == 2'd2) ? m_lfsr : step(m_lfsr);
        m_adj  <= (m_pend != 2'd0);
      end else begin
        m_adj  <= 1'b0;
      end
      m_ctr  <= ~m_ctr;
      m_t1   <= m_lfsr[14];
      m_t2   <= m_t1;
      m_pend <= np;
      m_lock <= nl;
      if (cfg_wr) begin m_thr <= cfg_thr; m_band <= cfg_band; end  // R11
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (run && !done) begin
      chk(code_early === m_lfsr[14], "R2 R6 R7 code phase", int'(code_early), int'(m_lfsr[14]));
      chk(code_prompt === m_t1, "R3 prompt tap", int'(code_prompt), int'(m_t1));
      chk(code_late === m_t2, "R3 late tap", int'(code_late), int'(m_t2));
      chk(enc_out === (data_in ^ m_t1), "R4 spread bit", int'(enc_out), int'(data_in ^ m_t1));
      chk(lock === m_lock, "R5 R8 R9 R11 lock", int'(lock), int'(m_lock));
      chk(adj_stb === m_adj, "R10 adjust strobe", int'(adj_stb), int'(m_adj));
    end
  end

  logic [3:0] dcnt = 4'd0;
  always @(negedge clk) begin
    dcnt    <= dcnt + 1'b1;
    data_in <= dcnt[0] ^ dcnt[3];
  end

  task automatic cfg(input int thr, input int band);
    @(negedge clk); cfg_wr = 1'b1; cfg_thr = PW'(thr); cfg_band = PW'(band);
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic measure(input int e, input int p, input int l);
    @(negedge clk);
    meas_valid = 1'b1; pwr_early = PW'(e); pwr_prompt = PW'(p); pwr_late = PW'(l);
    @(negedge clk); meas_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_thr = '0; cfg_band = '0;
    meas_valid = 1'b0; pwr_early = '0; pwr_prompt = '0; pwr_late = '0; data_in = 1'b0;
    run = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(lock === 1'b0 && adj_stb === 1'b0, "R1 reset flags", int'({lock, adj_stb}), 0);
    chk(code_early === 1'b0 && code_prompt === 1'b0, "R1 reset code", int'({code_early, code_prompt}), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);  // R2 free run
    // R11 default threshold 8, band 1
    measure(3, 8, 3);
    measure(3, 7, 3);
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 3; b++) begin
        cfg(4 + 5 * t, b * 2);  // R11
        for (int pi = 0; pi < 3; pi++) begin
          for (int e = 0; e < 6; e++) begin
            for (int l = 0; l < 6; l++) begin
              measure(e, (4 + 5 * t) - 1 + pi * 2 - (pi == 2 ? 1 : 0) * 0, l);
            end
          end
        end
      end
    end
    // Boundaries of the comparators at full scale
    cfg(255, 0);
    measure(255, 255, 254);
    measure(254, 255, 255);
    measure(255, 254, 255);
    measure(200, 255, 200);
    repeat (8) @(negedge clk);
    finish_run();
  end
endmodule